// File: doc/BRIEF.md
# Low-power lane turnaround controller

This block moves direction control of a bidirectional low-power lane from one end of a link to the other. It runs in one of two roles. While it owns the lane, a turnaround request makes it step the line through a fixed handover sequence. It then holds the bridge state (both wires low) and stops driving. While the far end owns the lane, it watches the sampled line. When the far end starts its own handover, the block waits a programmable settling interval and takes the lane. It holds the bridge state, signals that it owns the lane, and settles in the stop state as the new transmitter.

All intervals are whole multiples of one low-power unit length, called L. L is given in clock cycles on an input and is raised to a floor equivalent to 50 ns. L is latched when a sequence starts. The settling wait is programmable and is clamped between L and 2L. If the far end shows a line state that does not fit its handover, the block raises a one-cycle error pulse and stays in, or returns to, receive mode.

Top module: `lp_turnaround`

## Requirements
- R1: While reset is held, with the default initial role of owner, `line_out` is 2'b11, `line_oe` is 1, `is_tx` is 1 and `err_pulse` is 0.
- R2: Line codes put the P wire in bit 1 and the N wire in bit 0: stop = 2'b11, request = 2'b10, bridge = 2'b00. Suppose `ta_req` is sampled high at clock edge k while the block is the idle owner. The samples after edges k .. k+L-1 then show 2'b11, those after k+L .. k+2L-1 show 2'b10, and those after k+2L .. k+3L-1 show 2'b00, all with `line_oe` = 1 and `is_tx` = 1.
- R3: The bridge state 2'b00 is then held for exactly 4L more cycles (edges k+3L .. k+7L-1). From edge k+7L, `line_oe` = 0 and `is_tx` = 0.
- R4: L is `lpx_cyc` when `lpx_cyc` is at least LPX_MIN = ceil(50000 / CLK_PS), and LPX_MIN otherwise. LPX_MIN is 5 at the default 10000 ps clock.
- R5: In receive mode, a sample of 2'b10 on `line_in` at edge j starts a settling wait of S cycles. S is L if `sure_cyc` < L, 2L if `sure_cyc` > 2L, and `sure_cyc` otherwise. `line_oe` stays 0 through edge j+S-1 and rises at edge j+S. While the block does not drive, `line_out` reads 2'b11.
- R6: From edge j+S the block drives the bridge state 2'b00 for exactly 5L cycles, with `line_oe` = 1 and `is_tx` = 0.
- R7: It then drives 2'b10 for L cycles. At edge j+S+6L it drives 2'b11 with `is_tx` = 1 and is the idle owner.
- R8: During the settling wait, a `line_in` sample other than 2'b10 or 2'b00 raises `err_pulse` for the cycle after that edge. The block then returns to receive mode and does not take the lane.
- R9: In receive mode outside the settling wait, a `line_in` sample of 2'b00 or 2'b01 raises `err_pulse` for the cycle after that edge, and the block stays in receive mode.
- R10: `ta_req` has no effect unless the block is the idle owner. This covers receive mode and the middle of a handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ta_req | input | 1 | Request to hand the lane to the far end |
| line_in | input | 2 | Sampled far-end line state {P, N} |
| lpx_cyc | input | LPX_W | Unit length L in clock cycles, before the floor is applied |
| sure_cyc | input | LPX_W+1 | Requested settling wait in cycles, before the clamp |
| line_out | output | 2 | Driven line state {P, N} |
| line_oe | output | 1 | Line driver enable |
| is_tx | output | 1 | 1 while this end owns the lane |
| err_pulse | output | 1 | One-cycle pulse on an unexpected far-end state |

## Verification
Every output is decoded from registered state, so a request or line sample taken at edge k first shows in the sample after that edge. A phase of length D therefore covers the samples after edges k+a .. k+a+D-1. The bench drives inputs at the falling edge and samples every output at the falling edge of every cycle of a handover. It compares against windows computed from L and S: 3L + 4L for release, and S, 5L and L for take-over. The sweep covers several L values, including ones below the floor, and settling requests below, at, inside and above the clamp limits. Error pulses are expected exactly one sample after the bad input edge, and the block must show no take-over afterwards.

// File: rtl/lpta_pkg.sv
package lpta_pkg;

   typedef logic [1:0] lp_line_t;

   localparam lp_line_t LP_11 = 2'b11;
   localparam lp_line_t LP_10 = 2'b10;
   localparam lp_line_t LP_00 = 2'b00;
   localparam lp_line_t LP_01 = 2'b01;

   typedef enum logic [3:0] {
      ST_TX_IDLE,
      ST_REL11,
      ST_REL10,
      ST_REL00,
      ST_GO,
      ST_RX_IDLE,
      ST_SURE,
      ST_GET,
      ST_ACK10
   } lpta_state_e;

   function automatic lp_line_t drive_of(lpta_state_e s);
      case (s)
         ST_REL10, ST_ACK10:       return LP_10;
         ST_REL00, ST_GO, ST_GET:  return LP_00;
         default:                  return LP_11;
      endcase
   endfunction

endpackage

// File: rtl/lpta_span.sv
module lpta_span #(
   parameter int LPX_W   = 8,
   parameter int LPX_MIN = 5,
   parameter int CW      = LPX_W + 3
) (
   input  logic [LPX_W-1:0] lpx_cyc,
   input  logic [LPX_W:0]   sure_cyc,
   input  logic [LPX_W-1:0] lpx_hold,
   output logic [LPX_W-1:0] lpx_eff,
   output logic [CW-1:0]    first_last,
   output logic [CW-1:0]    sure_last,
   output logic [CW-1:0]    unit_last,
   output logic [CW-1:0]    go_last,
   output logic [CW-1:0]    get_last
);
   localparam logic [LPX_W-1:0] FLOOR = LPX_W'(LPX_MIN);
   localparam logic [CW-1:0]    ONE   = CW'(1);

   logic [LPX_W:0] lo, hi, sure_eff;
   logic [CW-1:0]  hold_w;

   always_comb begin
      lpx_eff  = (lpx_cyc < FLOOR) ? FLOOR : lpx_cyc;
      lo       = {1'b0, lpx_eff};
      hi       = {lpx_eff, 1'b0};
      if (sure_cyc < lo)      sure_eff = lo;
      else if (sure_cyc > hi) sure_eff = hi;
      else                    sure_eff = sure_cyc;
      hold_w     = CW'(lpx_hold);
      first_last = CW'(lpx_eff) - ONE;
      sure_last  = CW'(sure_eff) - ONE;
      unit_last  = hold_w - ONE;
      go_last    = (hold_w << 2) - ONE;
      get_last   = (hold_w << 2) + hold_w - ONE;
   end

endmodule

// File: rtl/lpta_phase_cnt.sv
module lpta_phase_cnt #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt,
   output logic          done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - CW'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/lpta_fsm.sv
module lpta_fsm
   import lpta_pkg::*;
#(
   parameter int LPX_W   = 8,
   parameter int LPX_MIN = 5,
   parameter int CW      = LPX_W + 3,
   parameter bit INIT_TX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ta_req,
   input  lp_line_t         line_in,
   input  logic [LPX_W-1:0] lpx_eff,
   input  logic [CW-1:0]    first_last,
   input  logic [CW-1:0]    sure_last,
   input  logic [CW-1:0]    unit_last,
   input  logic [CW-1:0]    go_last,
   input  logic [CW-1:0]    get_last,
   input  logic [CW-1:0]    cnt_val,
   input  logic             cnt_done,
   output logic             cnt_load,
   output logic [CW-1:0]    cnt_lval,
   output logic [LPX_W-1:0] lpx_hold,
   output lp_line_t         line_out,
   output logic             line_oe,
   output logic             is_tx,
   output logic             err_pulse
);
   localparam lpta_state_e RESET_ST = INIT_TX ? ST_TX_IDLE : ST_RX_IDLE;

   lpta_state_e st, st_nxt;
   logic        cap, err_nxt;

   always_comb begin
      st_nxt   = st;
      cnt_load = 1'b0;
      cnt_lval = '0;
      cap      = 1'b0;
      err_nxt  = 1'b0;
      case (st)
         ST_TX_IDLE: if (ta_req) begin
            st_nxt = ST_REL11; cnt_load = 1'b1; cnt_lval = first_last; cap = 1'b1;
         end
         ST_REL11: if (cnt_done) begin
            st_nxt = ST_REL10; cnt_load = 1'b1; cnt_lval = unit_last;
         end
         ST_REL10: if (cnt_done) begin
            st_nxt = ST_REL00; cnt_load = 1'b1; cnt_lval = unit_last;
         end
         ST_REL00: if (cnt_done) begin
            st_nxt = ST_GO; cnt_load = 1'b1; cnt_lval = go_last;
         end
         ST_GO: if (cnt_done) st_nxt = ST_RX_IDLE;
         ST_RX_IDLE: begin
            if (line_in == LP_10) begin
               st_nxt = ST_SURE; cnt_load = 1'b1; cnt_lval = sure_last; cap = 1'b1;
            end else if (line_in != LP_11) begin
               err_nxt = 1'b1;
            end
         end
         ST_SURE: begin
            if (line_in != LP_10 && line_in != LP_00) begin
               err_nxt = 1'b1; st_nxt = ST_RX_IDLE;
            end else if (cnt_done) begin
               st_nxt = ST_GET; cnt_load = 1'b1; cnt_lval = get_last;
            end
         end
         ST_GET: if (cnt_done) begin
            st_nxt = ST_ACK10; cnt_load = 1'b1; cnt_lval = unit_last;
         end
         ST_ACK10: if (cnt_done) st_nxt = ST_TX_IDLE;
         default: st_nxt = RESET_ST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RESET_ST;
         lpx_hold  <= LPX_W'(LPX_MIN);
         err_pulse <= 1'b0;
      end else begin
         st        <= st_nxt;
         err_pulse <= err_nxt;
         if (cap) lpx_hold <= lpx_eff;
      end
   end

   assign line_out = drive_of(st);
   assign line_oe  = (st != ST_RX_IDLE) && (st != ST_SURE);
   assign is_tx    = (st == ST_TX_IDLE) || (st == ST_REL11) || (st == ST_REL10) ||
                     (st == ST_REL00) || (st == ST_GO);

   assert_hold_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_TX_IDLE && st != ST_RX_IDLE) |-> (lpx_hold >= LPX_W'(LPX_MIN)));

   assert_sure_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SURE) |-> (cnt_val < (CW'(lpx_hold) << 1)));

   assert_bridge_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_oe) |-> ($past(line_out) == LP_00 && !is_tx));

   assert_flag_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_tx) |-> ($past(line_out) == LP_10 && line_out == LP_11 && line_oe));

   assert_err_in_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (!line_oe && !is_tx));

   assert_no_01_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> (line_out != LP_01));

   assert_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_oe && ta_req && line_in == LP_11) |=> (!line_oe && !is_tx));

endmodule

// File: rtl/lp_turnaround.sv
module lp_turnaround
   import lpta_pkg::*;
#(
   parameter int LPX_W   = 8,
   parameter int CLK_PS  = 10000,
   parameter bit INIT_TX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ta_req,
   input  logic [1:0]       line_in,
   input  logic [LPX_W-1:0] lpx_cyc,
   input  logic [LPX_W:0]   sure_cyc,
   output logic [1:0]       line_out,
   output logic             line_oe,
   output logic             is_tx,
   output logic             err_pulse
);
   localparam int LPX_MIN = (50000 + CLK_PS - 1) / CLK_PS;
   localparam int CW      = LPX_W + 3;

   initial begin
      assert (LPX_W >= 3) else $error("lp_turnaround: LPX_W must be at least 3");
      assert (CLK_PS > 0) else $error("lp_turnaround: CLK_PS must be positive");
      assert (LPX_MIN < (1 << LPX_W)) else $error("lp_turnaround: LPX floor does not fit LPX_W");
   end

   logic [LPX_W-1:0] lpx_eff, lpx_hold;
   logic [CW-1:0]    first_last, sure_last, unit_last, go_last, get_last;
   logic [CW-1:0]    cnt_val, cnt_lval;
   logic             cnt_done, cnt_load;

   lpta_span #(.LPX_W(LPX_W), .LPX_MIN(LPX_MIN), .CW(CW)) u_span (
      .lpx_cyc    (lpx_cyc),
      .sure_cyc   (sure_cyc),
      .lpx_hold   (lpx_hold),
      .lpx_eff    (lpx_eff),
      .first_last (first_last),
      .sure_last  (sure_last),
      .unit_last  (unit_last),
      .go_last    (go_last),
      .get_last   (get_last)
   );

   lpta_phase_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_lval),
      .cnt      (cnt_val),
      .done     (cnt_done)
   );

   lpta_fsm #(.LPX_W(LPX_W), .LPX_MIN(LPX_MIN), .CW(CW), .INIT_TX(INIT_TX)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ta_req     (ta_req),
      .line_in    (line_in),
      .lpx_eff    (lpx_eff),
      .first_last (first_last),
      .sure_last  (sure_last),
      .unit_last  (unit_last),
      .go_last    (go_last),
      .get_last   (get_last),
      .cnt_val    (cnt_val),
      .cnt_done   (cnt_done),
      .cnt_load   (cnt_load),
      .cnt_lval   (cnt_lval),
      .lpx_hold   (lpx_hold),
      .line_out   (line_out),
      .line_oe    (line_oe),
      .is_tx      (is_tx),
      .err_pulse  (err_pulse)
   );

endmodule

// File: tb/lp_turnaround_tb.sv
module lp_turnaround_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LPX_W      = 8;
   localparam int CLK_PS     = 10000;
   localparam int LPX_MIN    = 5;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             ta_req;
   logic [1:0]       line_in;
   logic [LPX_W-1:0] lpx_cyc;
   logic [LPX_W:0]   sure_cyc;
   logic [1:0]       line_out;
   logic             line_oe, is_tx, err_pulse;

   int checks = 0;
   int fails  = 0;
   bit done_f = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lp_turnaround #(.LPX_W(LPX_W), .CLK_PS(CLK_PS), .INIT_TX(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ta_req(ta_req), .line_in(line_in),
      .lpx_cyc(lpx_cyc), .sure_cyc(sure_cyc), .line_out(line_out),
      .line_oe(line_oe), .is_tx(is_tx), .err_pulse(err_pulse)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // exp packs {line_out[1:0], line_oe, is_tx, err_pulse}
   task automatic chk(string req, int i, int exp);
      int act;
      act = {27'd0, line_out, line_oe, is_tx, err_pulse};
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s cycle=%0d actual=%b expected=%b", req, i, act[4:0], exp[4:0]);
      end
   endtask

   function automatic int pk(int ln, int oe, int tx, int er);
      return (ln << 3) | (oe << 2) | (tx << 1) | er;
   endfunction

   task automatic do_release(int L);
      chk("R2 idle owner", -1, pk(3, 1, 1, 0));
      ta_req = 1'b1;
      step();
      ta_req = 1'b0;
      for (int i = 0; i <= 7*L; i++) begin
         if (i == L + 1) ta_req = 1'b1;   // R10: mid-sequence request
         if (i == L + 3) ta_req = 1'b0;
         if (i < L)          chk("R2 stop", i, pk(3, 1, 1, 0));
         else if (i < 2*L)   chk("R2 request", i, pk(2, 1, 1, 0));
         else if (i < 3*L)   chk("R2 bridge", i, pk(0, 1, 1, 0));
         else if (i < 7*L)   chk("R3 bridge hold", i, pk(0, 1, 1, 0));
         else                chk("R3 released", i, pk(3, 0, 0, 0));
         if (i < 7*L) step();
      end
   endtask

   task automatic do_acquire(int L, int S);
      line_in = 2'b11;
      ta_req  = 1'b1;                      // R10: ignored in receive mode
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R10 req ignored", i, pk(3, 0, 0, 0));
      end
      ta_req  = 1'b0;
      line_in = 2'b10;
      step();
      for (int i = 0; i <= S + 6*L; i++) begin
         if (i == L - 1) line_in = 2'b00;
         if (i < S)                chk("R5 sure wait", i, pk(3, 0, 0, 0));
         else if (i < S + 5*L)     chk("R6 bridge get", i, pk(0, 1, 0, 0));
         else if (i < S + 6*L)     chk("R7 request", i, pk(2, 1, 0, 0));
         else                      chk("R7 new owner", i, pk(3, 1, 1, 0));
         if (i < S + 6*L) step();
      end
      line_in = 2'b11;
   endtask

   task automatic err_sure(int L, int S, logic [1:0] bad);
      line_in = 2'b10;
      step();
      line_in = bad;
      step();
      chk("R8 error pulse", 1, pk(3, 0, 0, 1));
      line_in = 2'b11;
      for (int i = 2; i <= S + 6*L + 2; i++) begin
         step();
         chk("R8 no take-over", i, pk(3, 0, 0, 0));
      end
   endtask

   task automatic err_idle(logic [1:0] bad);
      line_in = bad;
      step();
      chk("R9 error pulse", 0, pk(3, 0, 0, 1));
      line_in = 2'b11;
      for (int i = 1; i < 6; i++) begin
         step();
         chk("R9 stays receive", i, pk(3, 0, 0, 0));
      end
   endtask

   initial begin
      int lpx_set[5]  = '{0, 3, 5, 6, 7};
      int L, S, sr;
      rst_n    = 1'b0;
      ta_req   = 1'b0;
      line_in  = 2'b11;
      lpx_cyc  = '0;
      sure_cyc = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset state", 0, pk(3, 1, 1, 0));
      rst_n = 1'b1;
      step();
      chk("R1 after reset", 1, pk(3, 1, 1, 0));

      for (int a = 0; a < 5; a++) begin
         L = (lpx_set[a] < LPX_MIN) ? LPX_MIN : lpx_set[a];   // R4 floor
         for (int b = 0; b < 7; b++) begin
            case (b)
               0: sr = 0;
               1: sr = 4;
               2: sr = L;
               3: sr = L + 1;
               4: sr = 2*L;
               5: sr = 2*L + 1;
               default: sr = 31;
            endcase
            S = (sr < L) ? L : ((sr > 2*L) ? 2*L : sr);
            lpx_cyc  = LPX_W'(lpx_set[a]);
            sure_cyc = (LPX_W+1)'(sr);
            do_release(L);
            do_acquire(L, S);
         end
      end

      lpx_cyc  = 8'd5;
      sure_cyc = '0;
      do_release(5);
      err_sure(5, 5, 2'b11);
      err_sure(5, 5, 2'b01);
      err_idle(2'b00);
      err_idle(2'b01);
      do_acquire(5, 5);

      done_f = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_f) begin
         fails++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule